// File: doc/BRIEF.md
# Packed Horizontal Add/Subtract Unit

This unit reduces two packed 128-bit integer vectors pairwise. Inside each operand, every two neighbouring elements are combined into one result element, either by adding them or by subtracting the higher-indexed element from the lower-indexed one. The reductions of both operands are then packed into a single 128-bit result. The element width is 16 or 32 bits. For 16-bit elements a signed saturating form is also available.

A producer presents an opcode and the two operands, called the first operand and the second operand, with a valid/ready handshake. The result is held in a single output register and is offered to a consumer through its own valid/ready pair. A new operation can be accepted in every cycle in which the output register is empty or is being drained. Only the datapath lives here. Decoding, register storage and operand fetch are the job of the surrounding logic.

Top module: `hsum_unit`

## Requirements
- R1: Each result element comes from two adjacent elements of one operand. With 16-bit elements, the reductions of the first operand fill result words 0..3 in ascending pair order, and the reductions of the second operand fill words 4..7. With 32-bit elements, the first operand fills dwords 0..1 and the second operand fills dwords 2..3.
- R2: Opcode 3'b000 adds each pair of signed 16-bit elements and keeps the low 16 bits of the sum, so overflow wraps.
- R3: Opcode 3'b001 adds each pair of signed 16-bit elements and clamps the sum to the range -32768..32767.
- R4: Opcode 3'b010 adds each pair of signed 32-bit elements with wraparound.
- R5: Opcode 3'b011 computes, for each 16-bit pair, element 2k minus element 2k+1, with wraparound.
- R6: Opcode 3'b100 computes the same 16-bit difference as R5 but clamps it to the range -32768..32767.
- R7: Opcode 3'b101 computes, for each 32-bit pair, element 2k minus element 2k+1, with wraparound.
- R8: Opcodes 3'b110 and 3'b111 produce an all-zero result with out_illegal set to 1. Every legal opcode produces out_illegal 0.
- R9: The output register loads only when in_valid and in_ready are both high. out_valid is high in the cycle after such an accept. When nothing is accepted and out_ready is high, out_valid falls and out_result keeps its value.
- R10: While out_valid is high and out_ready is low, in_ready is low, and out_result and out_valid hold.
- R11: A synchronous active-high rst clears out_valid, out_result and out_illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take an operation this cycle |
| in_op | input | 3 | Operation code |
| in_dst | input | 128 | First operand; its pair results go to the low half |
| in_src | input | 128 | Second operand; its pair results go to the high half |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_valid | output | 1 | out_result holds a new result |
| out_result | output | 128 | Packed pairwise results |
| out_illegal | output | 1 | The held result came from an undefined opcode |

## Verification
The bench uses a separate, distinct value in every element to expose a swapped pair or a swapped half. A design that reduced across the two operands, or put the second operand's results in the low half, would scramble those values.

Lanes at 0x7FFF and 0x8000 drive both the wrapping and the clamping forms past their limits. A design that clamped when it should wrap, wrapped when it should clamp, or reversed the order of the subtraction would return the wrong extreme. The 32-bit cases carry across the 16-bit boundary and also overflow, which catches a 16-bit adder wrongly used for 32-bit lanes.

Further tests cover:
- undefined opcodes, which must return zero and raise the flag;
- an idle cycle, which must neither reload the register nor keep out_valid high;
- a stalled consumer, while the producer keeps offering new data;
- a reset in mid-run.

// File: rtl/hsum_pkg.sv
package hsum_pkg;

    localparam int NARROW_W = 16;
    localparam int WIDE_W   = 32;

    typedef enum logic [2:0] {
        OP_ADD16  = 3'b000,
        OP_ADDS16 = 3'b001,
        OP_ADD32  = 3'b010,
        OP_SUB16  = 3'b011,
        OP_SUBS16 = 3'b100,
        OP_SUB32  = 3'b101
    } hsum_op_e;

    typedef struct packed {
        logic legal;
        logic wide;
        logic sub;
        logic sat;
    } hsum_ctrl_t;

    function automatic hsum_ctrl_t hsum_decode(input logic [2:0] code);
        hsum_ctrl_t c;
        c = '0;
        case (code)
            OP_ADD16:  c = '{legal: 1'b1, wide: 1'b0, sub: 1'b0, sat: 1'b0};
            OP_ADDS16: c = '{legal: 1'b1, wide: 1'b0, sub: 1'b0, sat: 1'b1};
            OP_ADD32:  c = '{legal: 1'b1, wide: 1'b1, sub: 1'b0, sat: 1'b0};
            OP_SUB16:  c = '{legal: 1'b1, wide: 1'b0, sub: 1'b1, sat: 1'b0};
            OP_SUBS16: c = '{legal: 1'b1, wide: 1'b0, sub: 1'b1, sat: 1'b1};
            OP_SUB32:  c = '{legal: 1'b1, wide: 1'b1, sub: 1'b1, sat: 1'b0};
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hsum_pair.sv
module hsum_pair #(
    parameter int EW      = 16,
    parameter bit HAS_SAT = 1'b1
) (
    input  logic [EW-1:0] lo,
    input  logic [EW-1:0] hi,
    input  logic          sub,
    input  logic          sat,
    output logic [EW-1:0] y
);

    localparam logic [EW-1:0] POS_LIM = {1'b0, {(EW-1){1'b1}}};
    localparam logic [EW-1:0] NEG_LIM = {1'b1, {(EW-1){1'b0}}};

    logic [EW:0] ext_lo;
    logic [EW:0] ext_hi;
    logic [EW:0] full;

    assign ext_lo = {lo[EW-1], lo};
    assign ext_hi = {hi[EW-1], hi};
    assign full   = sub ? (ext_lo - ext_hi) : (ext_lo + ext_hi);

    generate
        if (HAS_SAT) begin : g_sat
            logic over_pos;
            logic over_neg;
            assign over_pos = ~full[EW] &  full[EW-1];
            assign over_neg =  full[EW] & ~full[EW-1];
            always_comb begin
                if (sat && over_pos)      y = POS_LIM;
                else if (sat && over_neg) y = NEG_LIM;
                else                      y = full[EW-1:0];
            end
        end else begin : g_wrap
            logic unused_sat;
            assign unused_sat = sat;
            assign y = full[EW-1:0];
        end
    endgenerate

endmodule

// File: rtl/hsum_reduce.sv
module hsum_reduce #(
    parameter int VW      = 128,
    parameter int EW      = 16,
    parameter bit HAS_SAT = 1'b1
) (
    input  logic [VW-1:0]   vec,
    input  logic            sub,
    input  logic            sat,
    output logic [VW/2-1:0] red
);

    localparam int NPAIR = VW / (2 * EW);

    generate
        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            hsum_pair #(.EW(EW), .HAS_SAT(HAS_SAT)) u_pair (
                .lo  (vec[(2*p)*EW   +: EW]),
                .hi  (vec[(2*p+1)*EW +: EW]),
                .sub (sub),
                .sat (sat),
                .y   (red[p*EW +: EW])
            );
        end
    endgenerate

endmodule

// File: rtl/hsum_unit.sv
module hsum_unit
    import hsum_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       in_op,
    input  logic [VEC_W-1:0] in_dst,
    input  logic [VEC_W-1:0] in_src,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_result,
    output logic             out_illegal
);

    localparam int HALF_W = VEC_W / 2;
    localparam int NOPER  = 2;

    hsum_ctrl_t       ctrl;
    logic [VEC_W-1:0] opnd    [NOPER];
    logic [HALF_W-1:0] red_n  [NOPER];
    logic [HALF_W-1:0] red_w  [NOPER];
    logic [VEC_W-1:0] pack_n;
    logic [VEC_W-1:0] pack_w;
    logic [VEC_W-1:0] next_res;
    logic             accept;

    assign ctrl    = hsum_decode(in_op);
    assign opnd[0] = in_dst;
    assign opnd[1] = in_src;

    generate
        for (genvar g = 0; g < NOPER; g++) begin : g_opnd
            hsum_reduce #(.VW(VEC_W), .EW(NARROW_W), .HAS_SAT(1'b1)) u_narrow (
                .vec (opnd[g]),
                .sub (ctrl.sub),
                .sat (ctrl.sat),
                .red (red_n[g])
            );
            hsum_reduce #(.VW(VEC_W), .EW(WIDE_W), .HAS_SAT(1'b0)) u_wide (
                .vec (opnd[g]),
                .sub (ctrl.sub),
                .sat (1'b0),
                .red (red_w[g])
            );
        end
    endgenerate

    assign pack_n = {red_n[1], red_n[0]};
    assign pack_w = {red_w[1], red_w[0]};

    always_comb begin
        if (!ctrl.legal)    next_res = '0;
        else if (ctrl.wide) next_res = pack_w;
        else                next_res = pack_n;
    end

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_illegal <= 1'b0;
        end else if (accept) begin
            out_valid   <= 1'b1;
            out_result  <= next_res;
            out_illegal <= !ctrl.legal;
        end else if (out_ready) begin
            out_valid   <= 1'b0;
        end
    end

endmodule

// File: rtl/hsum_unit_chk.sv
module hsum_unit_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_ready,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_result,
    input logic             out_illegal
);

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_result == '0)); // R8

    AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid); // R9

    AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> $stable(out_result)); // R9

    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready); // R10

    AST_STALL_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result))); // R10

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0 && !out_illegal)); // R11

endmodule

bind hsum_unit hsum_unit_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/sim_hsum_unit.sv
`timescale 1ns/1ps
module sim_hsum_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [2:0]   in_op;
    logic [127:0] in_dst;
    logic [127:0] in_src;
    logic         out_ready;
    logic         out_valid;
    logic [127:0] out_result;
    logic         out_illegal;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    hsum_unit #(.VEC_W(128)) u0 (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
        .in_op (in_op), .in_dst (in_dst), .in_src (in_src),
        .out_ready (out_ready), .out_valid (out_valid),
        .out_result (out_result), .out_illegal (out_illegal)
    );

    localparam int NROW = 12;
    localparam logic [127:0] SEQ_D = 128'h0008_0007_0006_0005_0004_0003_0002_0001;
    localparam logic [127:0] SEQ_S = 128'h0080_0070_0060_0050_0040_0030_0020_0010;
    localparam logic [127:0] SEQ_ADD = 128'h00F0_00B0_0070_0030_000F_000B_0007_0003;
    localparam logic [127:0] MAXW = {8{16'h7FFF}};
    localparam logic [127:0] MINW = {8{16'h8000}};
    localparam logic [127:0] SD_D = {4{16'h0001, 16'h8000}};
    localparam logic [127:0] SD_S = {4{16'h8000, 16'h7FFF}};
    localparam logic [127:0] W_D  = {2{32'h0000_0001, 32'h7FFF_FFFF}};
    localparam logic [127:0] W_S  = {2{32'h0000_0003, 32'h0000_0005}};

    // row layout: {op[2:0], dst[127:0], src[127:0], expected[127:0]}
    localparam logic [386:0] ROWS [NROW] = '{
        {3'b000, SEQ_D, SEQ_S, SEQ_ADD},                                   // R1 R2
        {3'b011, SEQ_D, SEQ_S, {{4{16'hFFF0}}, {4{16'hFFFF}}}},            // R1 R5
        {3'b000, MAXW,  MINW,  {{4{16'h0000}}, {4{16'hFFFE}}}},            // R2 wrap
        {3'b001, MAXW,  MINW,  {{4{16'h8000}}, {4{16'h7FFF}}}},            // R3 clamp
        {3'b100, SD_D,  SD_S,  {{4{16'h7FFF}}, {4{16'h8000}}}},            // R6 clamp
        {3'b011, SD_D,  SD_S,  {{4{16'hFFFF}}, {4{16'h7FFF}}}},            // R5 wrap
        {3'b010, W_D,   W_S,   {{2{32'h0000_0008}}, {2{32'h8000_0000}}}},  // R4
        {3'b101, W_D,   W_S,   {{2{32'h0000_0002}}, {2{32'h7FFF_FFFE}}}},  // R7
        {3'b001, SEQ_D, SEQ_S, SEQ_ADD},                                   // R3 in range
        {3'b110, SEQ_D, SEQ_S, 128'h0},                                    // R8
        {3'b111, MAXW,  MINW,  128'h0},                                    // R8
        {3'b010, SEQ_D, SEQ_S, 128'h00E000C0_00600040_000E000C_00060004}   // R1 R4
    };

    function automatic string row_req(input int i);
        case (i)
            0: return "R1/R2";
            1: return "R1/R5";
            2: return "R2";
            3: return "R3";
            4: return "R6";
            5: return "R5";
            6: return "R4";
            7: return "R7";
            8: return "R3";
            9, 10: return "R8";
            default: return "R1/R4";
        endcase
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [386:0] r);
        in_valid = 1'b1;
        in_op    = r[386:384];
        in_dst   = r[383:256];
        in_src   = r[255:128];
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_dst = '0; in_src = '0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 reset valid", {127'b0, out_valid}, 128'd0);
        chk("R11 reset result", out_result, 128'd0);
        chk("R11 reset illegal", {127'b0, out_illegal}, 128'd0);

        for (int i = 0; i < NROW; i++) begin
            drive(ROWS[i]);
            @(negedge clk);
            in_valid = 1'b0;
            chk({row_req(i), " valid"}, {127'b0, out_valid}, 128'd1);
            chk({row_req(i), " result"}, out_result, ROWS[i][127:0]);
            chk({row_req(i), " illegal"}, {127'b0, out_illegal},
                {127'b0, (ROWS[i][386:384] > 3'd5)});
        end

        // R9: idle cycle, no accept
        in_valid = 1'b0; in_op = 3'b000; in_dst = MAXW; in_src = MAXW;
        @(negedge clk);
        chk("R9 idle valid drops", {127'b0, out_valid}, 128'd0);
        chk("R9 idle result held", out_result, ROWS[NROW-1][127:0]);

        // R10: stalled consumer
        drive(ROWS[0]);
        @(negedge clk);
        out_ready = 1'b0;
        drive(ROWS[2]);
        #1;
        chk("R10 in_ready low", {127'b0, in_ready}, 128'd0);
        @(negedge clk);
        chk("R10 stall valid", {127'b0, out_valid}, 128'd1);
        chk("R10 stall result", out_result, ROWS[0][127:0]);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 accept after stall", out_result, ROWS[2][127:0]);

        // R11: reset in mid-run
        drive(ROWS[6]);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 midrun valid", {127'b0, out_valid}, 128'd0);
        chk("R11 midrun result", out_result, 128'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule